// File: doc/BRIEF.md
# Base-Index-Displacement Effective Address Generator

This block turns the operand fields of a decoded instruction into an effective storage address. A base register number, an index register number and a 12-bit unsigned displacement are presented together with a start strobe. The block reads the two named general registers through two combinational read ports into a 16-entry bank of 32-bit registers. It adds whichever registers take part to the displacement, cuts the sum to the active address width and registers the result.

Register number zero never stands for the contents of register 0. It means that no register takes part in the sum. A form flag selects the indexed form, where base, index and displacement are summed, or the base-only form, where the index field has no effect. A mode flag selects between a 24-bit address space and a 31-bit address space. The result is zero-extended to 32 bits and appears, with a one-cycle valid pulse, on the clock after the start strobe.

Top module: `bxd_addr_gen`

## Requirements
- R1: While reset is active and on the first cycle after it is released, `ea_valid` is 0 and `ea` is 0.
- R2: `ea_valid` is 1 in exactly the cycle following a cycle in which `start` was 1 at the clock edge, and is 0 otherwise.
- R3: A base field of 0 adds nothing to the sum, whatever register 0 holds. With no index taking part, the address equals the displacement.
- R4: With `indexed` = 1, the address is the sum of base contents, index contents and displacement. An index field of 0 adds nothing.
- R5: With `indexed` = 0, the index field and the index register's contents have no effect on `ea`.
- R6: With `mode31` = 0, `ea[23:0]` equals the low 24 bits of the sum and `ea[31:24]` is 0.
- R7: With `mode31` = 1, `ea[30:0]` equals the low 31 bits of the sum and `ea[31]` is 0.
- R8: Carries beyond bit 31 of the sum are dropped. The result is the sum modulo 2^32 before truncation.
- R9: The displacement is an unsigned value from 0 to 4095 and is never sign-extended. A displacement of 0xFFF adds 4095.
- R10: `ea` keeps its value on every cycle that does not follow a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture the operand fields this cycle |
| indexed | input | 1 | 1 = indexed form, 0 = base-only form |
| mode31 | input | 1 | 1 = 31-bit addressing, 0 = 24-bit addressing |
| base_sel | input | 4 | Base register number (0 = none) |
| index_sel | input | 4 | Index register number (0 = none) |
| disp | input | 12 | Unsigned displacement |
| base_rd_addr | output | 4 | Register-bank read address for the base |
| base_rd_data | input | 32 | Register-bank read data for the base |
| index_rd_addr | output | 4 | Register-bank read address for the index |
| index_rd_data | input | 32 | Register-bank read data for the index |
| ea | output | 32 | Effective address, zero-extended |
| ea_valid | output | 1 | One-cycle strobe marking a fresh `ea` |

## Verification
The properties check on every cycle that the valid pulse follows each start by exactly one clock. They also check that the bits above the active address width are zero in both modes, that the address holds between starts, and that a base-less, index-less operand yields the bare displacement. Whether the summed value itself is right can only be shown by the bench's scenarios. These compare results against a sum computed from a known register image. They cover register 0 holding a nonzero value, an ignored index in the base-only form, the maximum displacement, and sums that carry past bit 31.

// File: rtl/bxd_addr_gen.sv
module bxd_addr_gen #(
  parameter int AW     = 32,
  parameter int RSEL   = 4,
  parameter int DW     = 12,
  parameter int NARROW = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            indexed,
  input  logic            mode31,
  input  logic [RSEL-1:0] base_sel,
  input  logic [RSEL-1:0] index_sel,
  input  logic [DW-1:0]   disp,
  output logic [RSEL-1:0] base_rd_addr,
  input  logic [AW-1:0]   base_rd_data,
  output logic [RSEL-1:0] index_rd_addr,
  input  logic [AW-1:0]   index_rd_data,
  output logic [AW-1:0]   ea,
  output logic            ea_valid
);
  localparam int WIDE = AW - 1;

  logic [AW-1:0] base_term, idx_term, sum, trimmed;

  assign base_rd_addr  = base_sel;
  assign index_rd_addr = index_sel;

  assign base_term = (base_sel != '0) ? base_rd_data : '0;
  assign idx_term  = (indexed && index_sel != '0) ? index_rd_data : '0;
  assign sum       = base_term + idx_term + AW'(disp);
  assign trimmed   = mode31 ? {{(AW-WIDE){1'b0}}, sum[WIDE-1:0]}
                            : {{(AW-NARROW){1'b0}}, sum[NARROW-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea       <= '0;
      ea_valid <= 1'b0;
    end else begin
      ea_valid <= start;
      if (start) ea <= trimmed;
    end
  end
endmodule

// File: rtl/bxd_addr_gen_props.sv
module bxd_addr_gen_props #(
  parameter int AW     = 32,
  parameter int RSEL   = 4,
  parameter int DW     = 12,
  parameter int NARROW = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            indexed,
  input logic            mode31,
  input logic [RSEL-1:0] base_sel,
  input logic [RSEL-1:0] index_sel,
  input logic [DW-1:0]   disp,
  input logic [AW-1:0]   ea,
  input logic            ea_valid
);
  p_valid_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ea_valid);
  p_no_stray_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !ea_valid);
  p_narrow_top_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !mode31) |=> (ea[AW-1:NARROW] == '0));
  p_wide_top_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode31) |=> !ea[AW-1]);
  p_hold_between_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(ea));
  p_disp_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && base_sel == '0 && (!indexed || index_sel == '0))
      |=> (ea == AW'($past(disp))));
endmodule

bind bxd_addr_gen bxd_addr_gen_props #(
  .AW(AW), .RSEL(RSEL), .DW(DW), .NARROW(NARROW)
) u_props (
  .clk(clk), .rst_n(rst_n), .start(start), .indexed(indexed),
  .mode31(mode31), .base_sel(base_sel), .index_sel(index_sel),
  .disp(disp), .ea(ea), .ea_valid(ea_valid)
);

// File: tb/bxd_addr_gen_test.sv
`timescale 1ns/1ps
module bxd_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        indexed = 1'b0;
  logic        mode31 = 1'b0;
  logic [3:0]  base_sel = '0;
  logic [3:0]  index_sel = '0;
  logic [11:0] disp = '0;
  logic [3:0]  base_rd_addr, index_rd_addr;
  logic [31:0] base_rd_data, index_rd_data;
  logic [31:0] ea;
  logic        ea_valid;
  logic [31:0] regs [16];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign base_rd_data  = regs[base_rd_addr];
  assign index_rd_data = regs[index_rd_addr];

  bxd_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .indexed(indexed),
    .mode31(mode31), .base_sel(base_sel), .index_sel(index_sel),
    .disp(disp), .base_rd_addr(base_rd_addr), .base_rd_data(base_rd_data),
    .index_rd_addr(index_rd_addr), .index_rd_data(index_rd_data),
    .ea(ea), .ea_valid(ea_valid)
  );

  // vector: {indexed, mode31, index_sel, base_sel, disp}
  localparam int NV = 12;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 1'b0, 4'd0, 4'd0, 12'h123},   // R3 displacement only
    {1'b1, 1'b1, 4'd0, 4'd0, 12'hFFF},   // R3 R9 both fields zero
    {1'b0, 1'b0, 4'd0, 4'd3, 12'h04A},   // base only, 24-bit
    {1'b0, 1'b1, 4'd0, 4'd3, 12'h04A},   // base only, 31-bit
    {1'b0, 1'b1, 4'd5, 4'd3, 12'h100},   // R5 index ignored
    {1'b1, 1'b1, 4'd5, 4'd3, 12'h100},   // R4 full indexed
    {1'b1, 1'b0, 4'd5, 4'd3, 12'h100},   // R4 R6 indexed 24-bit
    {1'b1, 1'b1, 4'd7, 4'd0, 12'h010},   // R3 index, no base
    {1'b1, 1'b1, 4'd0, 4'd7, 12'h010},   // R4 base, zero index
    {1'b1, 1'b1, 4'd14, 4'd15, 12'hFFF}, // R8 carry past bit 31
    {1'b1, 1'b0, 4'd14, 4'd15, 12'hFFF}, // R8 R6 carry, 24-bit
    {1'b0, 1'b1, 4'd0, 4'd9, 12'hFFF}    // R9 max displacement
  };

  function automatic logic [31:0] ref_ea(input logic ix, input logic m,
                                         input logic [3:0] x, input logic [3:0] b,
                                         input logic [11:0] d);
    logic [31:0] s;
    s = ((b != 0) ? regs[b] : 32'd0) + ((ix && x != 0) ? regs[x] : 32'd0)
        + {20'd0, d};
    return m ? {1'b0, s[30:0]} : {8'd0, s[23:0]};
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic ix, input logic m, input logic [3:0] x,
                        input logic [3:0] b, input logic [11:0] d, input string tag);
    logic [31:0] exp;
    exp = ref_ea(ix, m, x, b, d);
    @(negedge clk);
    indexed = ix; mode31 = m; index_sel = x; base_sel = b; disp = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(ea_valid === 1'b1, {tag, " R2 valid"}, {31'd0, ea_valid}, 32'd1);
    chk(ea === exp, tag, ea, exp);
  endtask

  initial begin
    regs[0] = 32'hFFFF_FFFF;
    for (int i = 1; i < 16; i++) regs[i] = 32'h9E37_79B9 * i + 32'h0101_0ACE;
    regs[3]  = 32'h8123_4560;
    regs[5]  = 32'h00F0_0F00;
    regs[7]  = 32'h7FFF_FFF8;
    regs[9]  = 32'h0000_0001;
    regs[14] = 32'hFFFF_FF00;
    regs[15] = 32'hC000_0000;

    repeat (3) @(negedge clk);
    chk(ea_valid === 1'b0, "R1 valid in reset", {31'd0, ea_valid}, 32'd0);
    chk(ea === 32'd0, "R1 ea in reset", ea, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ea_valid === 1'b0, "R1 valid after reset", {31'd0, ea_valid}, 32'd0);
    chk(ea === 32'd0, "R1 ea after reset", ea, 32'd0);

    for (int v = 0; v < NV; v++)
      run_op(VEC[v][21], VEC[v][20], VEC[v][19:16], VEC[v][15:12], VEC[v][11:0],
             $sformatf("R4 R6 R7 vector %0d", v));

    // R2 R10: valid drops and ea holds while idle, inputs changing
    begin
      logic [31:0] held;
      held = ea;
      @(negedge clk);
      base_sel = 4'd2; disp = 12'h777; mode31 = ~mode31;
      chk(ea_valid === 1'b0, "R2 valid drops", {31'd0, ea_valid}, 32'd0);
      repeat (3) @(negedge clk);
      chk(ea === held, "R10 ea held", ea, held);
    end

    // R2 back-to-back starts
    @(negedge clk);
    indexed = 1'b1; mode31 = 1'b1; index_sel = 4'd2; base_sel = 4'd4;
    disp = 12'h001; start = 1'b1;
    @(negedge clk);
    chk(ea === ref_ea(1, 1, 2, 4, 12'h001), "R2 first back-to-back", ea,
        ref_ea(1, 1, 2, 4, 12'h001));
    disp = 12'h002;
    @(negedge clk);
    start = 1'b0;
    chk(ea_valid === 1'b1, "R2 second valid", {31'd0, ea_valid}, 32'd1);
    chk(ea === ref_ea(1, 1, 2, 4, 12'h002), "R2 second back-to-back", ea,
        ref_ea(1, 1, 2, 4, 12'h002));

    // random register image and fields
    for (int i = 1; i < 16; i++) regs[i] = $urandom;
    regs[0] = $urandom | 32'h1;
    for (int n = 0; n < 60; n++)
      run_op(1'($urandom), 1'($urandom), 4'($urandom), 4'($urandom),
             12'($urandom), "R3 R4 R5 R8 random");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule